// File: doc/BRIEF.md
# Receive Shadow Buffer Swap Controller

The block sits between a frame receiver and message memory. It fills a spare "shadow" area in memory with the payload of each frame as it arrives. A received frame becomes visible only if the slot status shows a valid non-null frame. In that case the block does not copy the data. It exchanges the target buffer's memory index with the shadow index. The area that was just filled becomes the buffer, and the buffer's old area becomes the new shadow. The application therefore never sees a partly written or invalid frame.

Memory is organised as areas of `2**OFF_W` 16-bit words. An area is selected by an `IDX_W`-bit index, and a memory word address is `{index, offset}`. Offsets 0 to `2**OFF_W-2` hold payload. The last offset, all ones, holds the slot status word.

Every buffer belongs either to the static segment or to the dynamic segment. Each segment has its own shadow area and its own payload size setting. The host can disable or lock a buffer, and the block then leaves that buffer alone.

Control is a single state machine with these states:
- `ST_IDLE`: no frame in progress.
- `ST_RECV`: bytes are being taken.
- `ST_WAIT`: the frame has ended and the block waits for the slot boundary.
- `ST_EVAL`: the decision cycle after the boundary.
- `ST_COMMIT`: status is written into the shadow area and the indices swap.
- `ST_STWR`: status is written into the target's own area.
- `ST_LOST`: the frame-lost flag is set.

Transitions:
- IDLE→RECV on `frm_start`.
- RECV→EVAL on `slot_end`, which takes priority; RECV→WAIT on `frm_end`.
- WAIT→EVAL on `slot_end`.
- EVAL→IDLE if the target is disabled.
- EVAL→LOST if the target is locked.
- EVAL→COMMIT on a valid non-null status.
- EVAL→STWR for any other status.
- COMMIT, STWR and LOST return to IDLE.

Top module: `rxsb_ctrl`

## Requirements
- R1: After reset, buffer k holds index k. The static shadow index is `SPARE_STATIC` and the dynamic shadow index is `SPARE_DYN`. All lost flags are 0, `commit` is 0 and `mem_we` is 0.
- R2: Byte i of a frame, counted from 0 after `frm_start`, goes to word offset i/2 of the shadow area of the target's segment. `buf_seg` bit 0 selects static and bit 1 selects dynamic. An even byte goes in bits [7:0] and an odd byte in bits [15:8]. A completed word is written with `mem_be`=2'b11 in the cycle after its second byte is taken.
- R3: The number of bytes written is the smaller of the bytes received and twice the word setting of the target's segment. `words_static` applies to static buffers and `words_dyn` to dynamic buffers. Excess bytes are dropped.
- R4: A final odd byte is written alone with `mem_be`=2'b01. Words and bytes beyond the received length keep their earlier contents.
- R5: Valid non-null means status bit 0 = 1 and bit 1 = 0. At the slot boundary, with the target enabled and unlocked, such a status is written to the last word of the shadow area. The target's index and the segment's shadow index then exchange. Both indices change, and `commit` pulses for one cycle with `commit_buf` = target, two clock edges after the edge that samples `slot_end`.
- R6: Any other status is written to the last word of the target's current area. No index changes and no commit occur.
- R7: If `host_dis` of the target is 1, with or without its lock, the boundary causes no memory write, no index change and no flag.
- R8: If `host_lock` is 1 and `host_dis` is 0 for the target, the boundary causes no write and no index change. The target's lost flag is set instead, and it stays set until reset.
- R9: A `slot_end` while no frame is in progress is ignored.
- R10: A `slot_end` during reception ends the frame. A byte presented in the same cycle is still taken, and the frame is flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | Frame start pulse (taken in idle) |
| frm_buf | input | BUF_W | Target buffer of the starting frame |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| frm_end | input | 1 | Frame end pulse |
| slot_end | input | 1 | Slot boundary strobe |
| slot_status | input | 16 | Slot status word, sampled with `slot_end` |
| words_static | input | OFF_W | Payload words for static buffers |
| words_dyn | input | OFF_W | Payload words for dynamic buffers |
| buf_seg | input | NUM_BUF | Segment of each buffer (1 = dynamic) |
| host_dis | input | NUM_BUF | Buffer disabled by host |
| host_lock | input | NUM_BUF | Buffer locked by host |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | IDX_W+OFF_W | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_be | output | 2 | Byte lane enables |
| buf_idx | output | NUM_BUF*IDX_W | Index register of each buffer |
| shd_idx | output | 2*IDX_W | Shadow index, static then dynamic |
| lost | output | NUM_BUF | Sticky frame-lost flags |
| commit | output | 1 | One-cycle index exchange pulse |
| commit_buf | output | BUF_W | Buffer exchanged by the last commit |

## Verification
Two events can fall in the same cycle: the slot boundary and the last received byte. The bench provokes this by driving `slot_end` together with a final odd byte. The boundary must then both take the byte and flush it as a single-lane write in the decision cycle, and that write must land before the status write that follows. The bench judges the outcome from two sources: a memory image built from the write port, compared against a byte-level model, and per-clock checks of every index, flag and commit against the model.

// File: rtl/rxsb_pkg.sv
package rxsb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_WAIT,
        ST_EVAL,
        ST_COMMIT,
        ST_STWR,
        ST_LOST
    } rxsb_state_e;

    // Slot status encoding: bit 0 = frame valid, bit 1 = null frame.
    function automatic logic good_frame(input logic [15:0] st);
        return st[0] & ~st[1];
    endfunction

endpackage

// File: rtl/rxsb_packer.sv
module rxsb_packer #(
    parameter int OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [7:0]       byte_in,
    input  logic             flush,
    input  logic [OFF_W-1:0] limit_words,
    output logic             wr_en,
    output logic [OFF_W-1:0] wr_off,
    output logic [15:0]      wr_data,
    output logic [1:0]       wr_be
);
    localparam int CNT_W = OFF_W + 1;

    logic [CNT_W-1:0] byte_cnt;
    logic [CNT_W-1:0] byte_cap;
    logic [7:0]       lo_byte;
    logic             have_lo;
    logic             accept;

    assign byte_cap = {limit_words, 1'b0};
    assign accept   = take && (byte_cnt < byte_cap);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt <= '0;
            lo_byte  <= '0;
            have_lo  <= 1'b0;
            wr_en    <= 1'b0;
            wr_off   <= '0;
            wr_data  <= '0;
            wr_be    <= '0;
        end else if (clr) begin
            byte_cnt <= '0;
            have_lo  <= 1'b0;
            wr_en    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (accept) begin
                byte_cnt <= byte_cnt + 1'b1;
                wr_off   <= byte_cnt[CNT_W-1:1];
                if (have_lo) begin
                    wr_en   <= 1'b1;
                    wr_data <= {byte_in, lo_byte};
                    wr_be   <= 2'b11;
                    have_lo <= 1'b0;
                end else if (flush) begin
                    wr_en   <= 1'b1;
                    wr_data <= {8'h00, byte_in};
                    wr_be   <= 2'b01;
                end else begin
                    lo_byte <= byte_in;
                    have_lo <= 1'b1;
                end
            end else if (flush && have_lo) begin
                wr_en   <= 1'b1;
                wr_off  <= byte_cnt[CNT_W-1:1];
                wr_data <= {8'h00, lo_byte};
                wr_be   <= 2'b01;
                have_lo <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rxsb_index_bank.sv
module rxsb_index_bank #(
    parameter int             NUM_BUF      = 4,
    parameter int             IDX_W        = 3,
    parameter int             BUF_W        = 2,
    parameter logic [IDX_W-1:0] SPARE_STATIC = 3'd4,
    parameter logic [IDX_W-1:0] SPARE_DYN    = 3'd5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     swap_en,
    input  logic [BUF_W-1:0]         swap_buf,
    input  logic                     swap_seg,
    input  logic                     lost_en,
    input  logic [BUF_W-1:0]         lost_buf,
    output logic [NUM_BUF*IDX_W-1:0] buf_idx_flat,
    output logic [2*IDX_W-1:0]       shd_idx_flat,
    output logic [NUM_BUF-1:0]       lost,
    output logic                     commit,
    output logic [BUF_W-1:0]         commit_buf
);
    logic [IDX_W-1:0] buf_r [NUM_BUF];
    logic [IDX_W-1:0] shd_r [2];

    for (genvar k = 0; k < NUM_BUF; k++) begin : g_buf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                buf_r[k] <= IDX_W'(k);
                lost[k]  <= 1'b0;
            end else begin
                if (swap_en && (swap_buf == BUF_W'(k)))
                    buf_r[k] <= shd_r[swap_seg];
                if (lost_en && (lost_buf == BUF_W'(k)))
                    lost[k] <= 1'b1;
            end
        end
        assign buf_idx_flat[k*IDX_W +: IDX_W] = buf_r[k];
    end

    for (genvar s = 0; s < 2; s++) begin : g_shd
        localparam logic [IDX_W-1:0] SPARE = (s == 0) ? SPARE_STATIC : SPARE_DYN;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shd_r[s] <= SPARE;
            else if (swap_en && (swap_seg == 1'(s)))
                shd_r[s] <= buf_r[swap_buf];
        end
        assign shd_idx_flat[s*IDX_W +: IDX_W] = shd_r[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit     <= 1'b0;
            commit_buf <= '0;
        end else begin
            commit <= swap_en;
            if (swap_en)
                commit_buf <= swap_buf;
        end
    end

endmodule

// File: rtl/rxsb_fsm.sv
module rxsb_fsm
    import rxsb_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int BUF_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_start,
    input  logic [BUF_W-1:0]   frm_buf,
    input  logic               frm_end,
    input  logic               slot_end,
    input  logic [15:0]        slot_status,
    input  logic [NUM_BUF-1:0] buf_seg,
    input  logic [NUM_BUF-1:0] host_dis,
    input  logic [NUM_BUF-1:0] host_lock,
    output logic               recv_on,
    output logic               pk_clr,
    output logic               pk_flush,
    output logic [BUF_W-1:0]   tgt_buf,
    output logic               tgt_seg,
    output logic [15:0]        stat_q,
    output logic               st_we,
    output logic               st_to_shadow,
    output logic               swap_en,
    output logic               lost_en
);
    rxsb_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (frm_start) state_nxt = ST_RECV;
            ST_RECV: begin
                if (slot_end)     state_nxt = ST_EVAL;
                else if (frm_end) state_nxt = ST_WAIT;
            end
            ST_WAIT:   if (slot_end) state_nxt = ST_EVAL;
            ST_EVAL: begin
                if (host_dis[tgt_buf])        state_nxt = ST_IDLE;
                else if (host_lock[tgt_buf])  state_nxt = ST_LOST;
                else if (good_frame(stat_q))  state_nxt = ST_COMMIT;
                else                          state_nxt = ST_STWR;
            end
            ST_COMMIT: state_nxt = ST_IDLE;
            ST_STWR:   state_nxt = ST_IDLE;
            ST_LOST:   state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_buf <= '0;
            tgt_seg <= 1'b0;
            stat_q  <= '0;
        end else begin
            if (state == ST_IDLE && frm_start) begin
                tgt_buf <= frm_buf;
                tgt_seg <= buf_seg[frm_buf];
            end
            if ((state == ST_RECV || state == ST_WAIT) && slot_end)
                stat_q <= slot_status;
        end
    end

    always_comb begin
        recv_on      = 1'b0;
        pk_clr       = 1'b0;
        pk_flush     = 1'b0;
        st_we        = 1'b0;
        st_to_shadow = 1'b0;
        swap_en      = 1'b0;
        lost_en      = 1'b0;
        unique case (state)
            ST_IDLE:   pk_clr = frm_start;
            ST_RECV: begin
                recv_on  = 1'b1;
                pk_flush = frm_end | slot_end;
            end
            ST_WAIT, ST_EVAL: ;
            ST_COMMIT: begin
                st_we        = 1'b1;
                st_to_shadow = 1'b1;
                swap_en      = 1'b1;
            end
            ST_STWR:   st_we   = 1'b1;
            ST_LOST:   lost_en = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rxsb_ctrl.sv
module rxsb_ctrl #(
    parameter int             NUM_BUF      = 4,
    parameter int             IDX_W        = 3,
    parameter int             OFF_W        = 4,
    parameter logic [IDX_W-1:0] SPARE_STATIC = 3'd4,
    parameter logic [IDX_W-1:0] SPARE_DYN    = 3'd5,
    localparam int            BUF_W        = $clog2(NUM_BUF),
    localparam int            ADDR_W       = IDX_W + OFF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frm_start,
    input  logic [BUF_W-1:0]         frm_buf,
    input  logic                     rx_valid,
    input  logic [7:0]               rx_byte,
    input  logic                     frm_end,
    input  logic                     slot_end,
    input  logic [15:0]              slot_status,
    input  logic [OFF_W-1:0]         words_static,
    input  logic [OFF_W-1:0]         words_dyn,
    input  logic [NUM_BUF-1:0]       buf_seg,
    input  logic [NUM_BUF-1:0]       host_dis,
    input  logic [NUM_BUF-1:0]       host_lock,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [15:0]              mem_wdata,
    output logic [1:0]               mem_be,
    output logic [NUM_BUF*IDX_W-1:0] buf_idx,
    output logic [2*IDX_W-1:0]       shd_idx,
    output logic [NUM_BUF-1:0]       lost,
    output logic                     commit,
    output logic [BUF_W-1:0]         commit_buf
);
    logic             recv_on, pk_clr, pk_flush;
    logic [BUF_W-1:0] tgt_buf;
    logic             tgt_seg;
    logic [15:0]      stat_q;
    logic             st_we, st_to_shadow, swap_en, lost_en;
    logic             pk_we;
    logic [OFF_W-1:0] pk_off;
    logic [15:0]      pk_data;
    logic [1:0]       pk_be;
    logic [OFF_W-1:0] limit_words;
    logic [IDX_W-1:0] seg_shd;
    logic [IDX_W-1:0] tgt_idx;

    rxsb_fsm #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .frm_start(frm_start), .frm_buf(frm_buf), .frm_end(frm_end),
        .slot_end(slot_end), .slot_status(slot_status),
        .buf_seg(buf_seg), .host_dis(host_dis), .host_lock(host_lock),
        .recv_on(recv_on), .pk_clr(pk_clr), .pk_flush(pk_flush),
        .tgt_buf(tgt_buf), .tgt_seg(tgt_seg), .stat_q(stat_q),
        .st_we(st_we), .st_to_shadow(st_to_shadow),
        .swap_en(swap_en), .lost_en(lost_en)
    );

    assign limit_words = tgt_seg ? words_dyn : words_static;

    rxsb_packer #(.OFF_W(OFF_W)) packer_i (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr),
        .take(recv_on & rx_valid), .byte_in(rx_byte), .flush(pk_flush),
        .limit_words(limit_words),
        .wr_en(pk_we), .wr_off(pk_off), .wr_data(pk_data), .wr_be(pk_be)
    );

    rxsb_index_bank #(
        .NUM_BUF(NUM_BUF), .IDX_W(IDX_W), .BUF_W(BUF_W),
        .SPARE_STATIC(SPARE_STATIC), .SPARE_DYN(SPARE_DYN)
    ) bank_i (
        .clk(clk), .rst_n(rst_n),
        .swap_en(swap_en), .swap_buf(tgt_buf), .swap_seg(tgt_seg),
        .lost_en(lost_en), .lost_buf(tgt_buf),
        .buf_idx_flat(buf_idx), .shd_idx_flat(shd_idx),
        .lost(lost), .commit(commit), .commit_buf(commit_buf)
    );

    assign seg_shd = shd_idx[int'(tgt_seg)*IDX_W +: IDX_W];
    assign tgt_idx = buf_idx[int'(tgt_buf)*IDX_W +: IDX_W];

    always_comb begin
        if (st_we) begin
            mem_we    = 1'b1;
            mem_addr  = {(st_to_shadow ? seg_shd : tgt_idx), {OFF_W{1'b1}}};
            mem_wdata = stat_q;
            mem_be    = 2'b11;
        end else begin
            mem_we    = pk_we;
            mem_addr  = {seg_shd, pk_off};
            mem_wdata = pk_data;
            mem_be    = pk_we ? pk_be : 2'b00;
        end
    end

endmodule

// File: rtl/rxsb_ctrl_chk.sv
module rxsb_ctrl_chk #(
    parameter int NUM_BUF = 4,
    parameter int IDX_W   = 3,
    parameter int OFF_W   = 4,
    parameter int BUF_W   = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mem_we,
    input logic [IDX_W+OFF_W-1:0]   mem_addr,
    input logic [1:0]               mem_be,
    input logic [NUM_BUF*IDX_W-1:0] buf_idx,
    input logic [2*IDX_W-1:0]       shd_idx,
    input logic [NUM_BUF-1:0]       lost,
    input logic                     commit,
    input logic [BUF_W-1:0]         commit_buf
);
    localparam int ALL = NUM_BUF + 2;
    logic [IDX_W-1:0] all_idx [ALL];
    logic             dup;

    always_comb begin
        for (int i = 0; i < NUM_BUF; i++) all_idx[i] = buf_idx[i*IDX_W +: IDX_W];
        all_idx[NUM_BUF]   = shd_idx[IDX_W-1:0];
        all_idx[NUM_BUF+1] = shd_idx[2*IDX_W-1:IDX_W];
        dup = 1'b0;
        for (int i = 0; i < ALL; i++)
            for (int j = i + 1; j < ALL; j++)
                if (all_idx[i] == all_idx[j]) dup = 1'b1;
    end

    assert_unique_idx_R5: assert property (@(posedge clk) disable iff (!rst_n) !dup);

    assert_commit_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_status_before_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(mem_we) && ($past(mem_addr[OFF_W-1:0]) == {OFF_W{1'b1}})));

    assert_commit_changes_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (buf_idx[int'(commit_buf)*IDX_W +: IDX_W]
                    != $past(buf_idx[int'(commit_buf)*IDX_W +: IDX_W])));

    assert_no_swap_without_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |-> ($stable(buf_idx) && $stable(shd_idx)));

    assert_lane_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be == 2'b11 || mem_be == 2'b01));

    assert_lost_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lost & $past(lost)) == $past(lost)));

endmodule

bind rxsb_ctrl rxsb_ctrl_chk #(
    .NUM_BUF(NUM_BUF), .IDX_W(IDX_W), .OFF_W(OFF_W), .BUF_W(BUF_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .buf_idx(buf_idx), .shd_idx(shd_idx), .lost(lost),
    .commit(commit), .commit_buf(commit_buf)
);

// File: tb/rxsb_ctrl_tb_top.sv
module rxsb_ctrl_tb_top;
    localparam int NB = 4, IW = 3, OW = 4, BW = 2, AW = 7, NWORDS = 128;
    localparam int WS = 4, WD = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frm_start = 0, rx_valid = 0, frm_end = 0, slot_end = 0;
    logic [BW-1:0] frm_buf = '0;
    logic [7:0]  rx_byte = '0;
    logic [15:0] slot_status = '0;
    logic [OW-1:0] words_static = OW'(WS), words_dyn = OW'(WD);
    logic [NB-1:0] buf_seg = 4'b1100, host_dis = '0, host_lock = '0;
    logic mem_we, commit;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [1:0] mem_be;
    logic [NB*IW-1:0] buf_idx;
    logic [2*IW-1:0] shd_idx;
    logic [NB-1:0] lost;
    logic [BW-1:0] commit_buf;

    always #2 clk = ~clk;

    rxsb_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .frm_buf(frm_buf),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .frm_end(frm_end),
        .slot_end(slot_end), .slot_status(slot_status),
        .words_static(words_static), .words_dyn(words_dyn), .buf_seg(buf_seg),
        .host_dis(host_dis), .host_lock(host_lock), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .buf_idx(buf_idx), .shd_idx(shd_idx), .lost(lost), .commit(commit),
        .commit_buf(commit_buf)
    );

    int checks = 0, fails = 0;
    int m_buf[NB];
    int m_shd[2];
    bit m_lost[NB];
    bit m_commit = 0;
    int m_cbuf = 0;
    bit run_cmp = 0;
    int seed = 17;
    logic [15:0] mirror[NWORDS];
    logic [15:0] expm[NWORDS];

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (mem_be[0]) mirror[mem_addr][7:0]  = mem_wdata[7:0];
            if (mem_be[1]) mirror[mem_addr][15:8] = mem_wdata[15:8];
        end
    end

    // Per-clock comparison against the reference model
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            for (int k = 0; k < NB; k++) begin
                check(int'(buf_idx[k*IW +: IW]) == m_buf[k], "R5", "buffer index",
                      int'(buf_idx[k*IW +: IW]), m_buf[k]);
                check(lost[k] == m_lost[k], "R8", "lost flag", int'(lost[k]), int'(m_lost[k]));
            end
            for (int s = 0; s < 2; s++)
                check(int'(shd_idx[s*IW +: IW]) == m_shd[s], "R5", "shadow index",
                      int'(shd_idx[s*IW +: IW]), m_shd[s]);
            check(commit == m_commit, "R5", "commit pulse", int'(commit), int'(m_commit));
            if (m_commit)
                check(int'(commit_buf) == m_cbuf, "R5", "commit buffer", int'(commit_buf), m_cbuf);
        end
    end

    task automatic compare_image(string req);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < NWORDS; a++)
            if (mirror[a] !== expm[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s memory word %0d actual=%0d expected=%0d", req, first,
                     int'(mirror[first]), int'(expm[first]));
        end
    endtask

    task automatic run_frame(int tgt, int nb, bit bnd, logic [15:0] st, string req);
        int seg, shd, lim, a, old;
        logic [7:0] b;
        @(negedge clk);
        frm_start = 1; frm_buf = BW'(tgt);
        @(negedge clk);
        frm_start = 0;
        seg = int'(buf_seg[tgt]);
        shd = m_shd[seg];
        lim = (seg == 1) ? WD : WS;
        if (nb == 0 && !bnd) begin
            frm_end = 1;
            @(negedge clk);
            frm_end = 0;
        end
        for (int i = 0; i < nb; i++) begin
            seed = (seed * 13 + 7) % 251;
            b = 8'(seed);
            rx_valid = 1; rx_byte = b;
            if (i == nb - 1) begin
                if (bnd) begin slot_end = 1; slot_status = st; end
                else frm_end = 1;
            end
            if (i < 2 * lim) begin
                a = shd * 16 + i / 2;
                if (i % 2 == 0) expm[a][7:0] = b; else expm[a][15:8] = b;
            end
            @(negedge clk);
            rx_valid = 0; frm_end = 0;
        end
        if (!(bnd && nb > 0)) begin
            slot_end = 1; slot_status = st;
            @(negedge clk);
        end
        slot_end = 0;
        @(posedge clk);
        @(posedge clk);
        #1;
        if (host_dis[tgt]) begin
        end else if (host_lock[tgt]) begin
            m_lost[tgt] = 1;
        end else if (st[0] && !st[1]) begin
            expm[shd * 16 + 15] = st;
            old = m_buf[tgt];
            m_buf[tgt] = shd;
            m_shd[seg] = old;
            m_commit = 1;
            m_cbuf = tgt;
        end else begin
            expm[m_buf[tgt] * 16 + 15] = st;
        end
        @(posedge clk);
        #1 m_commit = 0;
        repeat (2) @(negedge clk);
        compare_image(req);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < NWORDS; a++) begin mirror[a] = '0; expm[a] = '0; end
        for (int k = 0; k < NB; k++) begin m_buf[k] = k; m_lost[k] = 0; end
        m_shd[0] = 4; m_shd[1] = 5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        for (int k = 0; k < NB; k++)
            check(int'(buf_idx[k*IW +: IW]) == k, "R1", "reset buffer index",
                  int'(buf_idx[k*IW +: IW]), k);
        check(int'(shd_idx) == ((5 << IW) | 4), "R1", "reset shadow indices",
              int'(shd_idx), (5 << IW) | 4);
        check(lost == '0, "R1", "reset lost flags", int'(lost), 0);
        check(!commit && !mem_we, "R1", "reset commit and write", int'({commit, mem_we}), 0);
        run_cmp = 1;

        run_frame(0, 5, 0, 16'h0001, "R2");   // odd length, static
        run_frame(1, 12, 0, 16'h0081, "R3");  // capped at 8 bytes
        run_frame(0, 8, 0, 16'h0000, "R6");   // invalid status
        run_frame(1, 3, 0, 16'h0011, "R4");   // short odd frame over stale data
        run_frame(2, 7, 1, 16'h0001, "R10");  // boundary with last byte
        run_frame(3, 4, 0, 16'h0003, "R6");   // null frame
        run_frame(3, 14, 0, 16'h0041, "R3");  // dynamic cap 12 bytes
        run_frame(2, 6, 0, 16'h0001, "R2");

        host_dis[0] = 1;
        run_frame(0, 4, 0, 16'h0001, "R7");
        host_lock[0] = 1;
        run_frame(0, 2, 0, 16'h0001, "R7");   // disabled and locked: no flag
        host_dis[0] = 0; host_lock[0] = 0;

        host_lock[1] = 1;
        run_frame(1, 4, 0, 16'h0001, "R8");
        run_frame(1, 3, 0, 16'h0000, "R8");
        host_lock[1] = 0;
        run_frame(1, 5, 0, 16'h0001, "R8");   // commit, flag stays set

        // R9: boundary with no frame in progress
        @(negedge clk);
        slot_end = 1; slot_status = 16'h0001;
        @(negedge clk);
        slot_end = 0;
        repeat (4) @(negedge clk);
        compare_image("R9");

        run_frame(2, 0, 0, 16'h0001, "R5");   // empty valid frame
        run_frame(0, 9, 1, 16'h0021, "R10");

        run_cmp = 0;
        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule